// File: doc/BRIEF.md
# MAC Interrupt Status and Acknowledge Controller

This block collects the interrupt sources of an Ethernet MAC into one six-bit status vector. A mask register of the same width selects which sources may raise the single interrupt output. Each bit keeps its own clearing rule. The receive-pending bit follows the state of the receive packet queue. The transmit-drained, allocation-done, early-receive and transmit-error bits are sticky: software clears them by writing ones to an acknowledge port. The excessive-collision bit clears when the MAC's transmit enable is set again.

The event sources are inputs from the buffer allocator and the MAC. Pulses from the allocator report that the transmit queue has drained and that an allocation has succeeded. The MAC supplies a start-of-frame pulse and a running byte count for the frame being received. It also supplies the transmit enable, the transmit-success flag and a sixteen-collision pulse. An internal comparator checks the byte count against a programmable early-receive threshold. A transmit-error detector reports a transmit enable that falls while transmit success is low, provided the error enable is set. Which pin the interrupt is routed to, and the bus protocol, are handled outside the block.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After reset, status_o, mask_o and irq_o are all zero. The transmit-error enable is off. The early-receive threshold is all ones.
- R2: Status bit 0 (receive pending) equals the inverse of rxq_empty sampled at the previous clock edge. Its value depends only on that input.
- R3: Status bit 1 (transmit drained) is set by txq_empty_evt. Status bit 2 (allocation done) is set by alloc_ok_evt. Each bit stays set until an ack_we write has a one in that bit position.
- R4: An acknowledge write has no effect on status bits 0 and 5. A zero in any acknowledge bit position leaves that status bit unchanged.
- R5: If a set event and an acknowledge of the same sticky bit arrive in the same cycle, the bit ends up set.
- R6: Status bit 3 (early receive) is set in the first cycle after rx_sof in which rx_bytes is strictly greater than the threshold. Equality does not set it. It fires at most once per frame. Each rx_sof re-arms it, and rx_bytes is ignored during the rx_sof cycle.
- R7: While the threshold holds its reset value (all ones), status bit 3 never sets.
- R8: Status bit 4 (transmit error) is set when tx_en goes from 1 to 0 while tx_ok is 0 and the error enable (te_we/te_wdata) is 1. It does not set when tx_ok is 1 or when the error enable is 0.
- R9: Status bit 5 (excessive collisions) is set by a coll16 pulse. It is cleared by a 0-to-1 transition of tx_en. Acknowledge writes do not clear it, and coll16 wins if both occur in the same cycle.
- R10: irq_o equals the OR of (status_o AND mask_o) as it was one cycle earlier. The mask is loaded by mask_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxq_empty | input | 1 | Receive packet queue is empty |
| txq_empty_evt | input | 1 | Pulse: transmit queue drained |
| alloc_ok_evt | input | 1 | Pulse: buffer allocation succeeded |
| rx_sof | input | 1 | Pulse: a new received frame starts |
| rx_bytes | input | CNT_W | Bytes stored so far for the current received frame |
| tx_en | input | 1 | MAC transmit enable |
| tx_ok | input | 1 | Last transmit succeeded |
| coll16 | input | 1 | Pulse: sixteen collisions on one frame |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | 6 | New mask value |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_wdata | input | 6 | Ones clear the matching sticky bits |
| thr_we | input | 1 | Load the early-receive threshold |
| thr_wdata | input | CNT_W | New threshold |
| te_we | input | 1 | Load the transmit-error enable |
| te_wdata | input | 1 | New transmit-error enable |
| status_o | output | 6 | Status vector |
| mask_o | output | 6 | Mask register |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with CNT_W = 8, so the byte count ranges over 0 to 255. With that width the reset threshold of 255 can be driven at its very top: a count of 255 does not fire the early-receive bit. A threshold of 10 tests the boundary between equal to and one above. Together, the narrow counter and the table walk let every sticky bit be set, acknowledged and raced within a few dozen cycles.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int NSRC   = 6;
  localparam int B_RXQ  = 0;
  localparam int B_TXE  = 1;
  localparam int B_ALC  = 2;
  localparam int B_ERX  = 3;
  localparam int B_EPH  = 4;
  localparam int B_XCOL = 5;
  localparam int NLAT   = B_EPH - B_TXE + 1;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_erx_cmp.sv
module irq_erx_cmp #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             thr_we,
  input  logic [CNT_W-1:0] thr_wdata,
  input  logic             sof,
  input  logic [CNT_W-1:0] bytes,
  output logic             hit_o,
  output logic [CNT_W-1:0] thr_o
);
  localparam logic [CNT_W-1:0] THR_RST = '1;
  logic armed;

  assign hit_o = armed && !sof && (bytes > thr_o);

  always_ff @(posedge clk) begin
    if (rst)         thr_o <= THR_RST;
    else if (thr_we) thr_o <= thr_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        armed <= 1'b0;
    else if (sof)   armed <= 1'b1;
    else if (hit_o) armed <= 1'b0;
  end
endmodule

// File: rtl/irq_txerr_det.sv
module irq_txerr_det (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic tx_ok,
  input  logic coll16,
  input  logic te_we,
  input  logic te_wdata,
  output logic err_evt_o,
  output logic xcol_o,
  output logic te_o
);
  logic tx_en_q;
  logic en_fall, en_rise;

  assign en_fall   = tx_en_q && !tx_en;
  assign en_rise   = !tx_en_q && tx_en;
  assign err_evt_o = en_fall && !tx_ok && te_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_q <= 1'b0;
      te_o    <= 1'b0;
      xcol_o  <= 1'b0;
    end else begin
      tx_en_q <= tx_en;
      if (te_we) te_o <= te_wdata;
      if (coll16)       xcol_o <= 1'b1;
      else if (en_rise) xcol_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
  import mac_irq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxq_empty,
  input  logic             txq_empty_evt,
  input  logic             alloc_ok_evt,
  input  logic             rx_sof,
  input  logic [CNT_W-1:0] rx_bytes,
  input  logic             tx_en,
  input  logic             tx_ok,
  input  logic             coll16,
  input  logic             mask_we,
  input  logic [5:0]       mask_wdata,
  input  logic             ack_we,
  input  logic [5:0]       ack_wdata,
  input  logic             thr_we,
  input  logic [CNT_W-1:0] thr_wdata,
  input  logic             te_we,
  input  logic             te_wdata,
  output logic [5:0]       status_o,
  output logic [5:0]       mask_o,
  output logic             irq_o
);
  logic             rxq_q;
  logic             erx_hit, eph_evt, xcol, te_en;
  logic [CNT_W-1:0] erx_thr;
  logic [NLAT-1:0]  lat_set, lat_clr, lat_q;

  irq_erx_cmp #(.CNT_W(CNT_W)) u_erx (
    .clk(clk), .rst(rst), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .sof(rx_sof), .bytes(rx_bytes), .hit_o(erx_hit), .thr_o(erx_thr)
  );

  irq_txerr_det u_txerr (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_ok(tx_ok), .coll16(coll16),
    .te_we(te_we), .te_wdata(te_wdata), .err_evt_o(eph_evt),
    .xcol_o(xcol), .te_o(te_en)
  );

  assign lat_set = {eph_evt, erx_hit, alloc_ok_evt, txq_empty_evt};
  assign lat_clr = ack_we ? ack_wdata[B_EPH:B_TXE] : '0;

  irq_evt_latch #(.W(NLAT)) u_lat (
    .clk(clk), .rst(rst), .set_i(lat_set), .clr_i(lat_clr), .q_o(lat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rxq_q  <= 1'b0;
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      rxq_q  <= !rxq_empty;
      if (mask_we) mask_o <= mask_wdata;
      irq_o  <= |(status_o & mask_o);
    end
  end

  assign status_o = {xcol, lat_q, rxq_q};
endmodule

// File: rtl/mac_irq_chk.sv
module mac_irq_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             rxq_empty,
  input logic             txq_empty_evt,
  input logic             rx_bytes_gt,
  input logic             tx_en,
  input logic             tx_ok,
  input logic             coll16,
  input logic             ack_we,
  input logic [5:0]       ack_wdata,
  input logic [5:0]       status_o,
  input logic [5:0]       mask_o,
  input logic             irq_o
);
  // R2: receive-pending bit tracks the queue flag with one cycle of lag
  p_rxq_level_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_o[0] == !$past(rxq_empty)));

  // R3: a set transmit-drained bit holds unless acknowledged
  p_txe_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (status_o[1] && !(ack_we && ack_wdata[1])) |=> status_o[1]);

  // R3: acknowledge with no competing event clears the bit
  p_txe_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (ack_we && ack_wdata[1] && !txq_empty_evt) |=> !status_o[1]);

  // R6: early-receive bit rises only after the count exceeded the threshold
  p_erx_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[3]) |-> $past(rx_bytes_gt));

  // R8: transmit-error bit rises only on a failed drop of transmit enable
  p_eph_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[4]) |-> ($past(tx_en, 2) && !$past(tx_en) && !$past(tx_ok)));

  // R9: re-enabling transmit clears the excessive-collision bit
  p_xcol_clr_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_en) && !coll16) |=> !status_o[5]);

  // R10: interrupt is the registered masked OR
  p_irq_comb_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(status_o & mask_o))));
endmodule

bind mac_irq_ctrl mac_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rxq_empty(rxq_empty), .txq_empty_evt(txq_empty_evt),
  .rx_bytes_gt(rx_bytes > erx_thr), .tx_en(tx_en), .tx_ok(tx_ok),
  .coll16(coll16), .ack_we(ack_we), .ack_wdata(ack_wdata),
  .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
);

// File: tb/sim_mac_irq_ctrl.sv
module sim_mac_irq_ctrl;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rxq_empty = 1'b1, txq_empty_evt = 1'b0, alloc_ok_evt = 1'b0;
  logic             rx_sof = 1'b0, tx_en = 1'b0, tx_ok = 1'b0, coll16 = 1'b0;
  logic [CNT_W-1:0] rx_bytes = '0, thr_wdata = '0;
  logic             mask_we = 1'b0, ack_we = 1'b0, thr_we = 1'b0;
  logic             te_we = 1'b0, te_wdata = 1'b0;
  logic [5:0]       mask_wdata = '0, ack_wdata = '0;
  logic [5:0]       status_o, mask_o;
  logic             irq_o;
  int               checks = 0, errors = 0;
  bit               done = 1'b0;

  always #10 clk = ~clk;

  mac_irq_ctrl #(.CNT_W(CNT_W)) u0 (.*);

  typedef struct packed {
    logic       rxe;
    logic       txe;
    logic       alc;
    logic       awe;
    logic [5:0] ack;
    logic [5:0] exp;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 6'b000000, 6'b000010},
    '{1'b0, 1'b0, 1'b1, 1'b0, 6'b000000, 6'b000111},
    '{1'b0, 1'b0, 1'b0, 1'b1, 6'b000001, 6'b000111},
    '{1'b0, 1'b0, 1'b0, 1'b1, 6'b000010, 6'b000101},
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'b000010, 6'b000110},
    '{1'b1, 1'b0, 1'b0, 1'b1, 6'b000100, 6'b000010},
    '{1'b1, 1'b0, 1'b0, 1'b1, 6'b111101, 6'b000010},
    '{1'b1, 1'b0, 1'b0, 1'b1, 6'b111111, 6'b000000}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    // R1: reset state
    check("R1 status", status_o, 6'b0);
    check("R1 mask", mask_o, 6'b0);
    check("R1 irq", irq_o, 1'b0);

    // R2 R3 R4 R5: table walk
    for (int i = 0; i < 8; i++) begin
      rxq_empty = TBL[i].rxe; txq_empty_evt = TBL[i].txe;
      alloc_ok_evt = TBL[i].alc; ack_we = TBL[i].awe; ack_wdata = TBL[i].ack;
      tick();
      txq_empty_evt = 1'b0; alloc_ok_evt = 1'b0; ack_we = 1'b0;
      check($sformatf("R2/R3/R4/R5 step %0d", i), status_o, TBL[i].exp);
    end

    // R10: masked interrupt with one-cycle lag
    mask_we = 1'b1; mask_wdata = 6'b000010; tick(); mask_we = 1'b0;
    check("R10 mask load", mask_o, 6'b000010);
    txq_empty_evt = 1'b1; tick(); txq_empty_evt = 1'b0;
    check("R10 irq lags status", irq_o, 1'b0);
    tick();
    check("R10 irq raised", irq_o, 1'b1);
    alloc_ok_evt = 1'b1; mask_we = 1'b1; mask_wdata = 6'b000000; tick();
    alloc_ok_evt = 1'b0; mask_we = 1'b0;
    tick();
    check("R10 irq masked off", irq_o, 1'b0);
    ack_we = 1'b1; ack_wdata = 6'b011110; tick(); ack_we = 1'b0;

    // R7: reset threshold (all ones) never fires
    rx_sof = 1'b1; rx_bytes = 8'd255; tick(); rx_sof = 1'b0;
    tick(); tick();
    check("R7 no fire at max count", status_o[3], 1'b0);

    // R6: strict compare, once per frame, re-arm on sof
    thr_we = 1'b1; thr_wdata = 8'd10; rx_bytes = 8'd0; tick(); thr_we = 1'b0;
    rx_sof = 1'b1; rx_bytes = 8'd50; tick(); rx_sof = 1'b0;
    check("R6 ignored during sof", status_o[3], 1'b0);
    rx_bytes = 8'd10; tick();
    check("R6 equal does not fire", status_o[3], 1'b0);
    rx_bytes = 8'd11; tick();
    check("R6 above fires", status_o[3], 1'b1);
    ack_we = 1'b1; ack_wdata = 6'b001000; rx_bytes = 8'd12; tick(); ack_we = 1'b0;
    tick();
    check("R6 once per frame", status_o[3], 1'b0);
    rx_sof = 1'b1; rx_bytes = 8'd0; tick(); rx_sof = 1'b0;
    rx_bytes = 8'd20; tick();
    check("R6 re-armed by sof", status_o[3], 1'b1);
    ack_we = 1'b1; ack_wdata = 6'b001000; tick(); ack_we = 1'b0;

    // R8: transmit error gated by enable and success
    tx_en = 1'b1; tick(); tx_en = 1'b0; tx_ok = 1'b0; tick();
    check("R8 enable off", status_o[4], 1'b0);
    te_we = 1'b1; te_wdata = 1'b1; tick(); te_we = 1'b0;
    tx_en = 1'b1; tick(); tx_ok = 1'b1; tx_en = 1'b0; tick();
    check("R8 success suppresses", status_o[4], 1'b0);
    tx_ok = 1'b0; tx_en = 1'b1; tick(); tx_en = 1'b0; tick();
    check("R8 error sets", status_o[4], 1'b1);
    ack_we = 1'b1; ack_wdata = 6'b010000; tick(); ack_we = 1'b0;
    check("R8 ack clears", status_o[4], 1'b0);

    // R9: excessive collisions
    coll16 = 1'b1; tick(); coll16 = 1'b0;
    check("R9 set", status_o[5], 1'b1);
    ack_we = 1'b1; ack_wdata = 6'b100000; tick(); ack_we = 1'b0;
    check("R9 ack ignored", status_o[5], 1'b1);
    tx_en = 1'b1; tick();
    check("R9 cleared by enable rise", status_o[5], 1'b0);

    finish_run();
  end
endmodule